// File: doc/BRIEF.md
# Two-List Translation Lookaside Buffer

This block caches virtual-to-physical page translations for 39-bit sign-extended virtual addresses with 4 KiB pages. It holds up to 128 translations in two circular lists of equal depth: an active list that receives new and recently reused translations, and an inactive list that holds entries pushed out of the active list. Both lists are compared against the requested virtual page number on every lookup. The result comes back one cycle later with a hit flag, the physical page number and the permission bits.

Replacement needs no per-entry age bits. Translations leave the active list in arrival order and move into the inactive list. Translations leave the inactive list in arrival order and are dropped. A hit in the inactive list copies that translation back to the active tail and leaves a vacated slot behind. In cycles with neither a lookup nor a refill, the inactive list drops its oldest slot while its occupancy is above a level chosen by the user. Refills come from an external walker.

Top module: `tlb_two_list`

## Requirements
- R1: After reset or after a `flush` cycle, every lookup misses. When `flush` and a refill share a cycle, the refill is lost. A lookup in a flush cycle is answered from the state before the flush.
- R2: A lookup presented in cycle N is answered in cycle N+1 with `rsp_valid` high. On a hit, `rsp_ppn` and `rsp_perm` are the values given when that page was refilled.
- R3: A lookup whose address bits 63 down to 39 are not all equal to bit 38 returns `rsp_fault`=1 and `rsp_hit`=0, and it changes neither list.
- R4: Every refill enters the active list. Each list holds 64 entries, so 128 distinct refills into an empty buffer all remain hittable.
- R5: A refill into a full active list moves the oldest active entry to the inactive tail, where it still hits.
- R6: A refill while both lists are full discards the oldest inactive slot. The oldest active entry then moves to the inactive list, and the new translation enters the active list.
- R7: A lookup that hits only in the inactive list copies the entry to the active tail and vacates its inactive slot. If the active list is full, the same demotion and discard as in R5 and R6 follow.
- R8: In a cycle with no lookup, no refill and no flush, if inactive occupancy is greater than `trim_level`, the oldest inactive slot is discarded. Occupancy counts vacated slots that have not yet reached the head.
- R9: A refill takes precedence over a promotion in the same cycle. The promotion is dropped, and the lookup response reflects the state before that cycle.
- R10: A hit in the active list does not change the order of either list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries this cycle |
| lkp_valid | input | 1 | Lookup request |
| lkp_va | input | 64 | Virtual address to translate |
| rfl_valid | input | 1 | Refill request |
| rfl_vpn | input | 27 | Virtual page number to insert |
| rfl_ppn | input | 28 | Physical page number to insert |
| rfl_perm | input | 8 | Permission bits to insert |
| trim_level | input | 7 | Inactive occupancy above which idle cycles discard |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Address was not sign-extended |
| rsp_ppn | output | 28 | Physical page number of the hit |
| rsp_perm | output | 8 | Permission bits of the hit |

## Verification
A refill and a promoting lookup can fall in the same cycle and compete for the active tail. The bench first fills both lists. It then issues a refill together with a lookup that hits an inactive entry. It checks that this lookup reports the hit and that the lookup which follows still finds the entry. Later lookups of the translations at both list heads show whether the promotion was dropped, because a promotion would have moved one more entry out of the active list and discarded one more from the inactive list.

// File: rtl/tlb2l_pkg.sv
package tlb2l_pkg;

    localparam int VA_W       = 64;
    localparam int SV_BITS    = 39;
    localparam int PAGE_SHIFT = 12;
    localparam int VPN_W      = SV_BITS - PAGE_SHIFT;
    localparam int PPN_W      = 28;
    localparam int PERM_W     = 8;
    localparam int EXT_W      = VA_W - SV_BITS + 1;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } xlat_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              fault;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } rsp_t;

    function automatic logic va_canonical(input logic [VA_W-1:0] va);
        return va[VA_W-1:SV_BITS-1] == {EXT_W{va[SV_BITS-1]}};
    endfunction

    function automatic logic [VPN_W-1:0] va_to_vpn(input logic [VA_W-1:0] va);
        return va[SV_BITS-1:PAGE_SHIFT];
    endfunction

endpackage

// File: rtl/tlb2l_search.sv
module tlb2l_search
    import tlb2l_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vld,
    input  xlat_t            ents [DEPTH],
    input  logic [VPN_W-1:0] key,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic [DEPTH-1:0] match;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = vld[g] && (ents[g].vpn == key);
        end
    endgenerate

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb2l_list.sv
module tlb2l_list
    import tlb2l_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push_en,
    input  xlat_t            push_data,
    input  logic             pop_en,
    input  logic             inval_en,
    input  logic [IDX_W-1:0] inval_idx,
    input  logic [VPN_W-1:0] key,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output xlat_t            hit_data,
    output xlat_t            head_data,
    output logic             full,
    output logic             empty,
    output logic [PTR_W-1:0] count
);

    localparam logic [PTR_W-1:0] WRAP_ONLY = {1'b1, {IDX_W{1'b0}}};

    xlat_t            mem [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [PTR_W-1:0] head_ptr, tail_ptr;
    logic [IDX_W-1:0] head_idx, tail_idx;

    assign head_idx  = head_ptr[IDX_W-1:0];
    assign tail_idx  = tail_ptr[IDX_W-1:0];
    assign count     = tail_ptr - head_ptr;
    assign full      = (head_ptr ^ tail_ptr) == WRAP_ONLY;
    assign empty     = head_ptr == tail_ptr;
    assign head_data = mem[head_idx];
    assign hit_data  = mem[hit_idx];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            vld      <= '0;
        end else begin
            if (inval_en) vld[inval_idx] <= 1'b0;
            if (pop_en) begin
                vld[head_idx] <= 1'b0;
                head_ptr      <= head_ptr + 1'b1;
            end
            if (push_en) begin
                vld[tail_idx] <= 1'b1;
                tail_ptr      <= tail_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_en && !rst && !flush) mem[tail_idx] <= push_data;
    end

    tlb2l_search #(.DEPTH(DEPTH)) u_search (
        .vld  (vld),
        .ents (mem),
        .key  (key),
        .hit  (hit),
        .idx  (hit_idx)
    );

    // R5: a push into a full list always comes with a pop
    a_r5_push_needs_room: assert property (@(posedge clk) disable iff (rst)
        push_en && full |-> pop_en);

    // R8: pops only take from an occupied list
    a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> !empty);

    // R7: only a live slot is vacated
    a_r7_inval_live: assert property (@(posedge clk) disable iff (rst)
        inval_en |-> vld[inval_idx]);

    // R1: flush leaves the list empty
    a_r1_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/tlb_two_list.sv
module tlb_two_list
    import tlb2l_pkg::*;
#(
    parameter int LIST_DEPTH = 64,
    localparam int IDX_W = $clog2(LIST_DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              lkp_valid,
    input  logic [VA_W-1:0]   lkp_va,
    input  logic              rfl_valid,
    input  logic [VPN_W-1:0]  rfl_vpn,
    input  logic [PPN_W-1:0]  rfl_ppn,
    input  logic [PERM_W-1:0] rfl_perm,
    input  logic [PTR_W-1:0]  trim_level,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm
);

    logic [VPN_W-1:0] key;
    logic             canon;
    xlat_t            rfl_data, ins_data;

    logic             a_hit, i_hit, a_full, i_full, a_empty, i_empty;
    logic [IDX_W-1:0] a_idx, i_idx;
    xlat_t            a_data, i_data, a_head, i_head;
    logic [PTR_W-1:0] a_count, i_count;

    logic do_rfl, do_prom, do_trim, do_ins;
    logic a_push, a_pop, i_push, i_pop, i_inval;

    rsp_t rsp_d, rsp_q;

    assign key      = va_to_vpn(lkp_va);
    assign canon    = va_canonical(lkp_va);
    assign rfl_data = '{vpn: rfl_vpn, ppn: rfl_ppn, perm: rfl_perm};

    // operation select: flush, then refill, then promotion, then idle trim
    always_comb begin
        do_rfl   = !flush && rfl_valid;
        do_prom  = !flush && !rfl_valid && lkp_valid && canon && !a_hit && i_hit;
        do_trim  = !flush && !rfl_valid && !lkp_valid && (i_count > trim_level);
        do_ins   = do_rfl || do_prom;
        ins_data = do_rfl ? rfl_data : i_data;
        a_push   = do_ins;
        a_pop    = do_ins && a_full;
        i_push   = a_pop;
        i_pop    = (a_pop && i_full) || do_trim;
        i_inval  = do_prom;
    end

    tlb2l_list #(.DEPTH(LIST_DEPTH)) u_active (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push_en   (a_push),
        .push_data (ins_data),
        .pop_en    (a_pop),
        .inval_en  (1'b0),
        .inval_idx ('0),
        .key       (key),
        .hit       (a_hit),
        .hit_idx   (a_idx),
        .hit_data  (a_data),
        .head_data (a_head),
        .full      (a_full),
        .empty     (a_empty),
        .count     (a_count)
    );

    tlb2l_list #(.DEPTH(LIST_DEPTH)) u_inactive (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push_en   (i_push),
        .push_data (a_head),
        .pop_en    (i_pop),
        .inval_en  (i_inval),
        .inval_idx (i_idx),
        .key       (key),
        .hit       (i_hit),
        .hit_idx   (i_idx),
        .hit_data  (i_data),
        .head_data (i_head),
        .full      (i_full),
        .empty     (i_empty),
        .count     (i_count)
    );

    // response built from the state before this cycle's update
    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = lkp_valid;
        if (lkp_valid) begin
            if (!canon) begin
                rsp_d.fault = 1'b1;
            end else if (a_hit) begin
                rsp_d.hit  = 1'b1;
                rsp_d.ppn  = a_data.ppn;
                rsp_d.perm = a_data.perm;
            end else if (i_hit) begin
                rsp_d.hit  = 1'b1;
                rsp_d.ppn  = i_data.ppn;
                rsp_d.perm = i_data.perm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_fault = rsp_q.fault;
    assign rsp_ppn   = rsp_q.ppn;
    assign rsp_perm  = rsp_q.perm;

    // R2: each request is answered on the next cycle
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        lkp_valid |=> rsp_valid);

    // R3: a fault never reports a hit
    a_r3_fault_excl: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> !rsp_hit);

    // R3: a faulting lookup alone leaves both lists untouched
    a_r3_fault_frozen: assert property (@(posedge clk) disable iff (rst)
        lkp_valid && !canon && !rfl_valid && !flush |=> $stable(a_count) && $stable(i_count));

    // R8: inactive occupancy only shrinks in idle cycles
    a_r8_busy_no_trim: assert property (@(posedge clk) disable iff (rst)
        (lkp_valid || rfl_valid) && !flush |=> i_count >= $past(i_count));

    // R4: a refill lands in the active list
    a_r4_refill_lands: assert property (@(posedge clk) disable iff (rst)
        rfl_valid && !flush |=> !a_empty);

endmodule

// File: tb/tlb_two_list_test.sv
module tlb_two_list_test;

    localparam int D = 64;

    logic        clk = 1'b0;
    logic        rst, flush, lkp_valid, rfl_valid;
    logic [63:0] lkp_va;
    logic [26:0] rfl_vpn;
    logic [27:0] rfl_ppn;
    logic [7:0]  rfl_perm;
    logic [6:0]  trim_level;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [27:0] rsp_ppn;
    logic [7:0]  rsp_perm;

    always #5 clk = ~clk;

    tlb_two_list uut (
        .clk(clk), .rst(rst), .flush(flush),
        .lkp_valid(lkp_valid), .lkp_va(lkp_va),
        .rfl_valid(rfl_valid), .rfl_vpn(rfl_vpn), .rfl_ppn(rfl_ppn), .rfl_perm(rfl_perm),
        .trim_level(trim_level),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm)
    );

    typedef struct {
        bit          v;
        logic [26:0] vpn;
        logic [27:0] ppn;
        logic [7:0]  perm;
    } ment_t;

    typedef struct {
        bit          hit;
        bit          fault;
        logic [27:0] ppn;
        logic [7:0]  perm;
        string       req;
    } exp_t;

    ment_t aq[$];
    ment_t iq[$];
    exp_t  sb[$];
    int    checks = 0;
    int    errors = 0;
    int    trim_m = 127;
    bit    done   = 0;

    function automatic logic [27:0] ppn_of(logic [26:0] v);
        return {1'b0, v} ^ 28'h5a5a5a5;
    endfunction

    function automatic logic [7:0] perm_of(logic [26:0] v);
        return v[7:0] ^ 8'h3c;
    endfunction

    function automatic logic [63:0] va_of(logic [26:0] v);
        return {{25{v[26]}}, v, 12'habc};
    endfunction

    function automatic bit in_model(logic [26:0] v);
        foreach (aq[i]) if (aq[i].vpn == v) return 1;
        foreach (iq[i]) if (iq[i].v && iq[i].vpn == v) return 1;
        return 0;
    endfunction

    task automatic m_insert(ment_t e);
        ment_t h;
        if (aq.size() == D) begin
            h = aq.pop_front();
            if (iq.size() == D) void'(iq.pop_front());
            iq.push_back(h);
        end
        aq.push_back(e);
    endtask

    // one clock cycle of stimulus, with the model advanced by the requirements
    task automatic step(bit lk, logic [63:0] va, bit rf, logic [26:0] vpn, bit fl, string req);
        exp_t  x;
        ment_t e;
        bit    canon;
        int    ka, ki;
        @(negedge clk);
        flush      = fl;
        lkp_valid  = lk;
        lkp_va     = va;
        rfl_valid  = rf;
        rfl_vpn    = vpn;
        rfl_ppn    = ppn_of(vpn);
        rfl_perm   = perm_of(vpn);
        trim_level = 7'(trim_m);
        canon = (va[63:38] == {26{va[38]}});
        ka = -1;
        ki = -1;
        if (lk) begin
            x = '{hit: 0, fault: !canon, ppn: '0, perm: '0, req: req};
            if (canon) begin
                foreach (aq[i]) if (ka < 0 && aq[i].vpn == va[38:12]) ka = i;
                if (ka < 0) foreach (iq[i]) if (ki < 0 && iq[i].v && iq[i].vpn == va[38:12]) ki = i;
                if (ka >= 0) begin
                    x.hit = 1; x.ppn = aq[ka].ppn; x.perm = aq[ka].perm;
                end else if (ki >= 0) begin
                    x.hit = 1; x.ppn = iq[ki].ppn; x.perm = iq[ki].perm;
                end
            end
            sb.push_back(x);
        end
        if (fl) begin
            aq.delete();
            iq.delete();
        end else if (rf) begin
            e = '{v: 1, vpn: vpn, ppn: ppn_of(vpn), perm: perm_of(vpn)};
            m_insert(e);
        end else if (lk && ki >= 0) begin
            e = iq[ki];
            iq[ki].v = 0;
            m_insert(e);
        end else if (!lk && iq.size() > trim_m) begin
            void'(iq.pop_front());
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, 0, "");
    endtask

    task automatic look(logic [26:0] v, string req);
        step(1, va_of(v), 0, '0, 0, req);
    endtask

    task automatic refill(logic [26:0] v);
        step(0, '0, 1, v, 0, "");
    endtask

    task automatic report;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d responses missing, expected 0", sb.size());
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: compare each response with the oldest expectation
    always @(negedge clk) begin
        exp_t x;
        if (!rst && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected response hit=%0b, expected none", rsp_hit);
            end else begin
                x = sb.pop_front();
                if (rsp_hit !== x.hit || rsp_fault !== x.fault ||
                    (x.hit && (rsp_ppn !== x.ppn || rsp_perm !== x.perm))) begin
                    errors++;
                    $display("FAIL %s: hit=%0b fault=%0b ppn=%h perm=%h, expected hit=%0b fault=%0b ppn=%h perm=%h",
                             x.req, rsp_hit, rsp_fault, rsp_ppn, rsp_perm,
                             x.hit, x.fault, x.ppn, x.perm);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

    initial begin
        logic [26:0] nv;
        rst = 1; flush = 0; lkp_valid = 0; rfl_valid = 0;
        lkp_va = '0; rfl_vpn = '0; rfl_ppn = '0; rfl_perm = '0; trim_level = 7'd127;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rsp_valid=%0b after reset, expected 0", rsp_valid);
        end

        // R1: empty after reset
        look(27'h10, "R1");
        // R2: refill then hit, including a negative-half page
        refill(27'h10);
        look(27'h10, "R2");
        refill(27'h4000123);
        look(27'h4000123, "R2");
        // R3: non-sign-extended address faults and changes nothing
        step(1, va_of(27'h10) ^ 64'h0004_0000_0000_0000, 0, '0, 0, "R3");
        look(27'h10, "R3");
        // R1: flush clears, flush beats refill, lookup in flush cycle sees old state
        step(1, va_of(27'h10), 0, '0, 1, "R1");
        look(27'h10, "R1");
        step(0, '0, 1, 27'h22, 1, "");
        look(27'h22, "R1");

        // R4: 128 distinct refills all still hit (active hits: R10, no reorder)
        for (int i = 0; i < 2 * D; i++) refill(27'(i * 3 + 27'h100));
        for (int i = 2 * D - 1; i >= D; i--) look(27'(i * 3 + 27'h100), "R10");
        for (int i = 0; i < 2; i++) refill(27'(27'h7000 + i));
        // R5/R6: oldest two inactive gone, demoted actives still hit
        look(27'h100, "R6");
        look(27'h103, "R6");
        look(27'(D * 3 + 27'h100), "R5");
        // R7: inactive hit promotes, forcing one more discard
        look(27'(10 * 3 + 27'h100), "R7");
        look(27'h106, "R7");
        look(27'(10 * 3 + 27'h100), "R7");
        // R9: refill and promoting lookup in the same cycle
        step(1, va_of(27'(20 * 3 + 27'h100)), 1, 27'h7100, 0, "R9");
        look(27'h7100, "R9");
        look(27'h109, "R9");
        look(27'h10c, "R9");
        look(27'(20 * 3 + 27'h100), "R9");
        // R9: lookup of a page refilled in the same cycle misses
        step(1, va_of(27'h7200), 1, 27'h7200, 0, "R9");
        look(27'h7200, "R9");

        // R8: idle trimming down to the level
        trim_m = 40;
        idle(40);
        for (int i = 0; i < D; i++) look(27'(i * 3 + 27'h100), "R8");
        trim_m = 127;

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            r  = int'($urandom_range(0, 9));
            nv = 27'($urandom_range(0, 299)) | (r[0] ? 27'h4000000 : 27'h0);
            if (r < 4 && !in_model(nv)) refill(nv);
            else if (r == 9) step(1, va_of(nv) ^ 64'h8000_0000_0000_0000, 0, '0, 0, "R3");
            else if (r == 8) step(1, va_of(nv), !in_model(nv ^ 27'h1), nv ^ 27'h1, 0, "R9");
            else if (n % 500 == 499) begin
                trim_m = int'($urandom_range(20, 100));
                idle(20);
                trim_m = 127;
            end else look(nv, "R7");
        end

        idle(3);
        done = 1;
        report();
    end

endmodule